// File: doc/BRIEF.md
# Post-Increment Load Sequencer

This block is a multi-cycle controller and datapath that runs one 24-bit "load, then bump the pointer" instruction for a small 8-bit machine with four registers. A pulse on `start` gives it the address of the instruction. It fetches the instruction one byte at a time from a byte-wide instruction memory. That memory answers combinationally to the registered `imem_addr` while `imem_en` is high.

The first two bytes name a destination register and a pointer register. As soon as they are decoded, the block reads data memory at the pointer's current value and writes the returned word into the destination register. Data memory is synchronous, with one cycle of read latency. Only after that write does the block fetch the third byte, an unsigned step value, and add it to the pointer register modulo 256. A one-cycle `done` pulse ends each instruction.

An instruction with an unknown opcode is stopped at decode and flags `err`. The register file has no write port at the edge. Its contents are seen through a registered debug read port and change only through executed instructions.

Top module: `postinc_load_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle, clears all four registers to 0, and the next cycle shows `done`, `err`, `imem_en` and `dmem_rd` all at 0.
- R2: The instruction bytes sit at `instr_addr`, `instr_addr+1` and `instr_addr+2`. In byte 0, bits 7:2 hold the opcode and bits 1:0 hold the destination index. In byte 1, bits 1:0 hold the pointer index and bits 7:2 are ignored. Byte 2 is the step value. Opcode `010000` is the only legal one.
- R3: A legal instruction raises `dmem_rd` for exactly one cycle, with `dmem_addr` equal to the pointer register's value before the increment. The destination register receives the word that memory returns one cycle later.
- R4: After the load, the pointer register holds its old value plus the step, modulo 256. The other registers are unchanged apart from the destination.
- R5: When the destination and pointer indices are equal, that register ends as the loaded word plus the step, modulo 256.
- R6: A legal instruction holds `imem_en` high for exactly three cycles. The fetch of byte 2 happens only after the `dmem_rd` cycle.
- R7: For a legal instruction, `done` is high for one cycle, 9 clock edges after the edge that accepts `start`. The accepting edge counts as the first.
- R8: An illegal opcode raises `err` together with `done` for one cycle, 4 edges after the accepting edge. In that case there is no data read, no register changes, and only two bytes are fetched.
- R9: `start` is accepted only in the idle state or in the cycle where `done` is high. Accepting it in the `done` cycle begins the next instruction at once. `start` during any other busy cycle is ignored.
- R10: `dbg_data` shows the register selected by `dbg_sel` one clock edge after the selection is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the instruction at `instr_addr` |
| instr_addr | input | 8 | Address of instruction byte 0, sampled with `start` |
| imem_en | output | 1 | Instruction byte fetch in this cycle |
| imem_addr | output | 8 | Instruction byte address |
| imem_rdata | input | 8 | Instruction byte at `imem_addr` |
| dmem_rd | output | 1 | Data read request |
| dmem_addr | output | 8 | Data read address |
| dmem_rdata | input | 8 | Data word, valid the cycle after `dmem_rd` |
| dbg_sel | input | 2 | Register index for the debug port |
| dbg_data | output | 8 | Registered value of the selected register |
| done | output | 1 | One-cycle end-of-instruction pulse |
| err | output | 1 | Illegal opcode, high together with `done` |

## Verification
Two events can share a cycle: the `done` pulse of one instruction and the acceptance of the next `start`. The bench provokes this by raising `start` in the very cycle where it sees `done`. It then checks that the second instruction keeps the 9-edge latency, reads from the pointer value the first one left behind, and leaves both results in the register file. It also raises `start` in the middle of an instruction and checks that no extra fetch follows `done`.

// File: rtl/plu_pkg.sv
package plu_pkg;
  localparam int IBW   = 8;  // instruction byte width
  localparam int OPC_W = 6;  // opcode field width, top of byte 0

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BYTE0,
    ST_BYTE1,
    ST_DECODE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_LOAD_WB,
    ST_BYTE2,
    ST_BUMP,
    ST_FINISH
  } plu_state_e;
endpackage

// File: rtl/plu_regfile.sv
module plu_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RIW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RIW-1:0] raddr,
  output logic [DW-1:0]  rdata,
  input  logic [RIW-1:0] dbg_sel,
  output logic [DW-1:0]  dbg_data
);
  logic [DW-1:0] ents [NREG];

  // one register per entry, cleared by reset (R1)
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (rst)
        ent_q <= '0;
      else if (we && waddr == RIW'(g))
        ent_q <= wdata;
    end
    assign ents[g] = ent_q;
  end

  assign rdata = ents[raddr];

  // registered debug view (R10)
  always_ff @(posedge clk) begin
    if (rst)
      dbg_data <= '0;
    else
      dbg_data <= ents[dbg_sel];
  end
endmodule

// File: rtl/plu_decode.sv
module plu_decode
  import plu_pkg::*;
#(
  parameter int              RIW    = 2,
  parameter logic [OPC_W-1:0] OPCODE = 6'b010000
) (
  input  logic [IBW-1:0] byte0,
  input  logic [RIW-1:0] byte1_idx,
  output logic [RIW-1:0] dst_idx,
  output logic [RIW-1:0] ptr_idx,
  output logic           legal
);
  // R2: opcode in bits 7:2 of byte 0, destination in its low bits
  assign legal   = (byte0[IBW-1 -: OPC_W] == OPCODE);
  assign dst_idx = byte0[RIW-1:0];
  assign ptr_idx = byte1_idx;
endmodule

// File: rtl/plu_ctrl.sv
module plu_ctrl
  import plu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       legal,
  output plu_state_e state_q,
  output plu_state_e state_d,
  output logic       done,
  output logic       err
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_BYTE0;
      ST_BYTE0:   state_d = ST_BYTE1;
      ST_BYTE1:   state_d = ST_DECODE;
      ST_DECODE:  state_d = legal ? ST_RD_REQ : ST_FINISH;
      ST_RD_REQ:  state_d = ST_RD_WAIT;
      ST_RD_WAIT: state_d = ST_LOAD_WB;
      ST_LOAD_WB: state_d = ST_BYTE2;
      ST_BYTE2:   state_d = ST_BUMP;
      ST_BUMP:    state_d = ST_FINISH;
      // R9: a start in the finishing cycle chains the next instruction
      ST_FINISH:  state_d = start ? ST_BYTE0 : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (state_d == ST_FINISH);
      err     <= (state_q == ST_DECODE) && !legal;
    end
  end
endmodule

// File: rtl/postinc_load_unit.sv
module postinc_load_unit
  import plu_pkg::*;
#(
  parameter int               DW     = 8,
  parameter int               IAW    = 8,
  parameter int               NREG   = 4,
  parameter logic [OPC_W-1:0] OPCODE = 6'b010000,
  localparam int              RIW    = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [IAW-1:0] instr_addr,
  output logic           imem_en,
  output logic [IAW-1:0] imem_addr,
  input  logic [IBW-1:0] imem_rdata,
  output logic           dmem_rd,
  output logic [DW-1:0]  dmem_addr,
  input  logic [DW-1:0]  dmem_rdata,
  input  logic [RIW-1:0] dbg_sel,
  output logic [DW-1:0]  dbg_data,
  output logic           done,
  output logic           err
);
  plu_state_e state_q, state_d;

  logic [IBW-1:0] byte0_q;
  logic [RIW-1:0] byte1_q;
  logic [DW-1:0]  mdr_q;
  logic [DW-1:0]  step_q;
  logic [RIW-1:0] dst_idx, ptr_idx;
  logic           legal;

  logic           rf_we;
  logic [RIW-1:0] rf_waddr;
  logic [DW-1:0]  rf_wdata;
  logic [DW-1:0]  ptr_val;

  plu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .legal   (legal),
    .state_q (state_q),
    .state_d (state_d),
    .done    (done),
    .err     (err)
  );

  plu_decode #(.RIW(RIW), .OPCODE(OPCODE)) u_dec (
    .byte0     (byte0_q),
    .byte1_idx (byte1_q),
    .dst_idx   (dst_idx),
    .ptr_idx   (ptr_idx),
    .legal     (legal)
  );

  plu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .raddr    (ptr_idx),
    .rdata    (ptr_val),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data)
  );

  // single write port: load write-back, then pointer bump (R3, R4, R5)
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dst_idx;
    rf_wdata = mdr_q;
    if (state_q == ST_LOAD_WB) begin
      rf_we = 1'b1;
    end else if (state_q == ST_BUMP) begin
      rf_we    = 1'b1;
      rf_waddr = ptr_idx;
      rf_wdata = ptr_val + step_q;  // wraps modulo 2**DW
    end
  end

  // fetch sequencing (R2, R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      imem_en   <= 1'b0;
      imem_addr <= '0;
    end else begin
      imem_en <= (state_d == ST_BYTE0) || (state_d == ST_BYTE1) ||
                 (state_d == ST_BYTE2);
      if (state_d == ST_BYTE0)
        imem_addr <= instr_addr;
      else if (state_d == ST_BYTE1 || state_d == ST_BYTE2)
        imem_addr <= imem_addr + IAW'(1);
    end
  end

  // byte capture and holding registers
  always_ff @(posedge clk) begin
    if (rst) begin
      byte0_q <= '0;
      byte1_q <= '0;
      step_q  <= '0;
      mdr_q   <= '0;
    end else begin
      if (state_q == ST_BYTE0)   byte0_q <= imem_rdata;
      if (state_q == ST_BYTE1)   byte1_q <= imem_rdata[RIW-1:0];
      if (state_q == ST_BYTE2)   step_q  <= DW'(imem_rdata);
      if (state_q == ST_RD_WAIT) mdr_q   <= dmem_rdata;
    end
  end

  // data read request, address is the pointer before the bump (R3)
  always_ff @(posedge clk) begin
    if (rst) begin
      dmem_rd   <= 1'b0;
      dmem_addr <= '0;
    end else begin
      dmem_rd <= (state_d == ST_RD_REQ);
      if (state_q == ST_DECODE)
        dmem_addr <= ptr_val;
    end
  end
endmodule

// File: rtl/plu_chk.sv
module plu_chk (
  input logic clk,
  input logic rst,
  input logic done,
  input logic err,
  input logic imem_en,
  input logic dmem_rd
);
  logic [1:0] fetch_cnt;
  logic       rd_seen;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      fetch_cnt <= '0;
      rd_seen   <= 1'b0;
    end else begin
      if (imem_en && fetch_cnt != 2'd3) fetch_cnt <= fetch_cnt + 2'd1;
      if (dmem_rd) rd_seen <= 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!done && !err && !imem_en && !dmem_rd));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_rd |=> !dmem_rd);

  // R6
  step_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    (imem_en && fetch_cnt == 2'd2) |-> rd_seen);

  // R6
  fetch_limit_chk: assert property (@(posedge clk) disable iff (rst)
    imem_en |-> (fetch_cnt != 2'd3));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R8
  err_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!rd_seen && !dmem_rd));
endmodule

bind postinc_load_unit plu_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .done    (done),
  .err     (err),
  .imem_en (imem_en),
  .dmem_rd (dmem_rd)
);

// File: tb/tb_postinc_load_unit.sv
module tb_postinc_load_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] instr_addr = '0;
  logic       imem_en;
  logic [7:0] imem_addr;
  logic [7:0] imem_rdata;
  logic       dmem_rd;
  logic [7:0] dmem_addr;
  logic [7:0] dmem_rdata = '0;
  logic [1:0] dbg_sel = '0;
  logic [7:0] dbg_data;
  logic       done, err;

  always #10 clk = ~clk;  // 50 MHz

  postinc_load_unit dut (
    .clk(clk), .rst(rst), .start(start), .instr_addr(instr_addr),
    .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_rd(dmem_rd), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .done(done), .err(err)
  );

  // instruction memory: answers only while a fetch is requested
  logic [7:0] irom [256];
  assign imem_rdata = imem_en ? irom[imem_addr] : 8'hA5;

  function automatic logic [7:0] dval(input logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  always @(posedge clk) if (dmem_rd) dmem_rdata <= dval(dmem_addr);

  // activity monitor, sampled away from the active edge
  int         fcnt, rdcnt;
  logic       order_bad;
  logic [7:0] rd_addr_seen, cur_base;
  always @(negedge clk) begin
    if (imem_en) begin
      fcnt++;
      if (imem_addr == 8'(cur_base + 8'd2) && rdcnt == 0) order_bad = 1'b1;
    end
    if (dmem_rd) begin
      rdcnt++;
      rd_addr_seen = dmem_addr;
    end
  end

  int nchk = 0, nbad = 0;
  logic [7:0] mreg [4];

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_instr(input logic [7:0] base, b0, b1, b2,
                           input bit poke, output int lat);
    irom[base] = b0;
    irom[8'(base + 8'd1)] = b1;
    irom[8'(base + 8'd2)] = b2;
    fcnt = 0; rdcnt = 0; order_bad = 1'b0; cur_base = base;
    instr_addr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      start = (poke && lat == 4);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  task automatic do_legal(input logic [1:0] ri, rj, input logic [7:0] x,
                          input logic [5:0] rsv, input logic [7:0] base,
                          input bit poke);
    logic [7:0] old_ptr;
    int lat;
    old_ptr = mreg[rj];
    run_instr(base, {6'b010000, ri}, {rsv, rj}, x, poke, lat);
    mreg[ri] = dval(old_ptr);
    mreg[rj] = mreg[rj] + x;
    check("R7", "latency", lat, 9);
    check("R8", "err on legal", err, 0);
    check("R3", "read count", rdcnt, 1);
    check("R3", "read address", rd_addr_seen, old_ptr);
    check("R6", "fetch count", fcnt, 3);
    check("R6", "step fetched before load", order_bad, 0);
  endtask

  task automatic check_regs(input int ri, input int rj);
    for (int k = 0; k < 4; k++) begin
      dbg_sel = 2'(k);
      @(negedge clk);
      if (k == ri && k == rj) check("R5", "shared register", dbg_data, mreg[k]);
      else if (k == rj)       check("R4", "pointer register", dbg_data, mreg[k]);
      else if (k == ri)       check("R3", "destination register", dbg_data, mreg[k]);
      else                    check("R4", "untouched register", dbg_data, mreg[k]);
    end
  endtask

  // {dst, ptr, step, reserved bits of byte 1}
  localparam logic [17:0] VEC [8] = '{
    {2'd1, 2'd0, 8'h20, 6'h00},
    {2'd2, 2'd1, 8'h05, 6'h00},
    {2'd3, 2'd3, 8'h10, 6'h00},
    {2'd0, 2'd2, 8'hFF, 6'h2A},
    {2'd2, 2'd2, 8'hF0, 6'h00},
    {2'd1, 2'd3, 8'h81, 6'h15},
    {2'd3, 2'd0, 8'h00, 6'h00},
    {2'd0, 2'd1, 8'h7F, 6'h3F}
  };

  logic [1:0] v_ri, v_rj;
  logic [7:0] v_x;
  logic [5:0] v_rsv;
  logic [7:0] hold;
  int         lat_i;

  initial begin
    for (int a = 0; a < 256; a++) irom[a] = 8'h00;
    for (int k = 0; k < 4; k++) mreg[k] = 8'h00;
    fcnt = 0; rdcnt = 0; order_bad = 1'b0; cur_base = 8'h00; rd_addr_seen = '0;

    // reset state (R1, R10)
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "done after reset", done, 0);
    check("R1", "err after reset", err, 0);
    check("R1", "imem_en after reset", imem_en, 0);
    check("R1", "dmem_rd after reset", dmem_rd, 0);
    check_regs(-1, -1);

    // table walk (R2..R7)
    for (int i = 0; i < 8; i++) begin
      v_ri = VEC[i][17:16];
      v_rj = VEC[i][15:14];
      v_x = VEC[i][13:6];
      v_rsv = VEC[i][5:0];
      do_legal(v_ri, v_rj, v_x, v_rsv, 8'(8'h10 + 3 * i), 1'b0);
      check_regs(int'(v_ri), int'(v_rj));
    end

    // R10: debug output changes only one edge after selection
    dbg_sel = 2'd1;
    @(negedge clk);
    hold = dbg_data;
    dbg_sel = 2'd2;
    #1;
    check("R10", "debug held before edge", dbg_data, hold);
    @(negedge clk);
    check("R10", "debug after edge", dbg_data, mreg[2]);

    // R8: illegal opcodes
    run_instr(8'h40, {6'b010001, 2'd1}, 8'h02, 8'h33, 1'b0, lat_i);
    check("R8", "illegal latency", lat_i, 4);
    check("R8", "err with done", err, 1);
    check("R8", "no data read", rdcnt, 0);
    check("R8", "two fetches", fcnt, 2);
    @(negedge clk);
    check("R8", "err one cycle", err, 0);
    check_regs(-1, -1);
    run_instr(8'hFE, 8'h00, 8'h00, 8'h01, 1'b0, lat_i);
    check("R8", "zero opcode err", err, 1);
    check("R8", "zero opcode latency", lat_i, 4);
    @(negedge clk);

    // R9: start mid-instruction ignored
    do_legal(2'd0, 2'd3, 8'h09, 6'h00, 8'h50, 1'b1);
    fcnt = 0;
    repeat (12) @(negedge clk);
    check("R9", "no fetch after busy start", fcnt, 0);
    check_regs(0, 3);

    // R9: start in the done cycle chains the next instruction
    do_legal(2'd2, 2'd1, 8'h11, 6'h00, 8'h60, 1'b0);
    check("R9", "done seen before chain", done, 1);
    do_legal(2'd3, 2'd1, 8'h22, 6'h00, 8'h70, 1'b0);
    check_regs(3, 1);

    // R1: reset in the middle of an instruction
    irom[8'h80] = {6'b010000, 2'd1};
    irom[8'h81] = 8'h00;
    irom[8'h82] = 8'h04;
    instr_addr = 8'h80;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) mreg[k] = 8'h00;
    check("R1", "mid reset done", done, 0);
    check("R1", "mid reset imem_en", imem_en, 0);
    check("R1", "mid reset dmem_rd", dmem_rd, 0);
    check_regs(-1, -1);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nchk++;
    nbad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule